// File: doc/BRIEF.md
# Converter Result Byte-Bus Interface

This block connects the result register of an integrating analog-to-digital converter to an 8-bit microprocessor data bus. The result is a 15-bit magnitude with a sign flag and an overrange flag. The block qualifies the bus strobes with a two-signal chip selection. In on-demand operation, a write strobe asks the converter to begin a conversion. The block places the stored result on the bus one byte at a time. The three-state bus is modelled as a data value plus an output enable.

There are two modes. In on-demand mode the host chooses the byte with a high/low select input. When the high byte is shown, a second select input decides whether the top bus bit carries the sign or the overrange flag. In continuous mode the host needs no address lines. It reads three times in a row and receives a status byte, then the high byte, then the low byte. A fresh result restarts that order. A result that arrives while a read is under way waits until the read ends, so a byte never changes under the host.

Top module: `adc_bus_if`

## Requirements
- R1: The block is selected only while `cs` is 1 and `ce_n` is 0. Neither a read nor a write has any effect while it is not selected.
- R2: In on-demand mode (`cont_mode` = 0), a selected write (`wr_n` = 0) raises `conv_start` for exactly one clock cycle, in the cycle after the write is first seen. Holding the write longer produces no further pulse.
- R3: `db_oe` is 1 only during a selected read (`rd_n` = 0). While `db_oe` is 0, `db_out` is all zeros. After reset both outputs and `conv_start` are 0.
- R4: In on-demand mode, `byte_hi` = 0 presents magnitude bits 7..0. `byte_hi` = 1 presents magnitude bits 14..8 on bus bits 6..0.
- R5: In on-demand mode, bus bit 7 of the high byte carries the overrange flag when `ovr_sel` = 1 and the sign flag (1 = negative) when `ovr_sel` = 0.
- R6: In continuous mode, successive selected reads return three bytes in a fixed order. The first is the status byte, with the sign on bit 7, overrange on bit 6 and zeros below. The second is the high byte, with 0 on bit 7 and magnitude bits 14..8 below. The third is the low byte. The position advances when a selected read ends, and it wraps from the low byte back to the status byte.
- R7: Storing a new result returns the continuous-mode position to the status byte.
- R8: A write has no effect in continuous mode, and it has no effect while `conv_busy` is 1.
- R9: A result offered on `res_valid` during a selected read is held back and stored only once the read has ended. If several results arrive, the newest one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select, active high |
| ce_n | input | 1 | Chip enable, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cont_mode | input | 1 | 1 = continuous mode, 0 = on-demand mode |
| byte_hi | input | 1 | On-demand byte select: 1 = high byte, 0 = low byte |
| ovr_sel | input | 1 | On-demand top-bit select: 1 = overrange, 0 = sign |
| conv_busy | input | 1 | Converter is busy with a conversion |
| res_valid | input | 1 | One-cycle strobe offering a new result |
| res_mag | input | 15 | Result magnitude |
| res_neg | input | 1 | Result sign, 1 = negative |
| res_ovr | input | 1 | Result overrange flag |
| db_out | output | 8 | Bus data value |
| db_oe | output | 1 | Bus output enable |
| conv_start | output | 1 | One-cycle conversion start request |

## Verification
The main patterns are on-demand reads across all four combinations of `byte_hi` and `ovr_sel`. They use results whose sign and overrange flags differ from each other, so a swapped top bit is caught. The magnitudes use distinct high and low bytes, so swapped byte halves are caught. Continuous reads run past the wrap point, and they are also interrupted by a fresh result, which separates the advance rule from the restart rule. A result delivered in the middle of a read, followed by a second read, shows whether the update was held back or lost. Writes are tried while selected, while not selected, while busy and in continuous mode, which tells the gating terms apart.

// File: rtl/adcbus_pkg.sv
package adcbus_pkg;
    typedef enum logic [1:0] {
        SLOT_STAT = 2'd0,
        SLOT_HIGH = 2'd1,
        SLOT_LOW  = 2'd2
    } slot_e;
endpackage

// File: rtl/adcbus_decode.sv
module adcbus_decode (
    input  logic cs,
    input  logic ce_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic rd_act,
    output logic wr_act
);
    logic sel;
    always_comb begin
        sel    = cs & ~ce_n;
        rd_act = sel & ~rd_n;
        wr_act = sel & ~wr_n;
    end
endmodule

// File: rtl/adcbus_start.sv
module adcbus_start (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_act,
    input  logic cont_mode,
    input  logic conv_busy,
    output logic conv_start
);
    typedef struct packed {
        logic wr_seen;
        logic start;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.wr_seen = wr_act;
        s_d.start   = wr_act & ~s_q.wr_seen & ~cont_mode & ~conv_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign conv_start = s_q.start;
endmodule

// File: rtl/adcbus_latch.sv
module adcbus_latch #(
    parameter int MAG_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [MAG_W-1:0] res_mag,
    input  logic             res_neg,
    input  logic             res_ovr,
    input  logic             rd_act,
    output logic [MAG_W-1:0] lat_mag,
    output logic             lat_neg,
    output logic             lat_ovr,
    output logic             load
);
    typedef struct packed {
        logic             pend;
        logic [MAG_W-1:0] p_mag;
        logic             p_neg;
        logic             p_ovr;
        logic [MAG_W-1:0] mag;
        logic             neg;
        logic             ovr;
    } lt_t;

    lt_t l_d, l_q;

    always_comb begin
        l_d  = l_q;
        load = (res_valid | l_q.pend) & ~rd_act;
        if (res_valid) begin
            l_d.pend  = 1'b1;
            l_d.p_mag = res_mag;
            l_d.p_neg = res_neg;
            l_d.p_ovr = res_ovr;
        end
        if (load) begin
            l_d.pend = 1'b0;
            l_d.mag  = l_d.p_mag;
            l_d.neg  = l_d.p_neg;
            l_d.ovr  = l_d.p_ovr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign lat_mag = l_q.mag;
    assign lat_neg = l_q.neg;
    assign lat_ovr = l_q.ovr;
endmodule

// File: rtl/adcbus_mux.sv
module adcbus_mux #(
    parameter int MAG_W = 15,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_act,
    input  logic             cont_mode,
    input  logic             byte_hi,
    input  logic             ovr_sel,
    input  logic             load,
    input  logic [MAG_W-1:0] lat_mag,
    input  logic             lat_neg,
    input  logic             lat_ovr,
    output logic [BUS_W-1:0] db_out,
    output logic             db_oe,
    output logic [1:0]       seq_o
);
    import adcbus_pkg::*;

    localparam int HI_W = MAG_W - BUS_W;

    typedef struct packed {
        logic  rd_seen;
        slot_e seq;
    } mx_t;

    mx_t m_d, m_q;
    logic [BUS_W-1:0] lo_byte, hi_byte, hi_plain, stat_byte, pick;

    always_comb begin
        m_d         = m_q;
        m_d.rd_seen = rd_act;
        if (load) begin
            m_d.seq = SLOT_STAT;
        end else if (cont_mode && m_q.rd_seen && !rd_act) begin
            case (m_q.seq)
                SLOT_STAT: m_d.seq = SLOT_HIGH;
                SLOT_HIGH: m_d.seq = SLOT_LOW;
                default:   m_d.seq = SLOT_STAT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '{rd_seen: 1'b0, seq: SLOT_STAT};
        else        m_q <= m_d;
    end

    always_comb begin
        lo_byte   = lat_mag[BUS_W-1:0];
        hi_byte   = {(ovr_sel ? lat_ovr : lat_neg), lat_mag[MAG_W-1 -: HI_W]};
        hi_plain  = {1'b0, lat_mag[MAG_W-1 -: HI_W]};
        stat_byte = {lat_neg, lat_ovr, {(BUS_W-2){1'b0}}};
        if (cont_mode) begin
            case (m_q.seq)
                SLOT_STAT: pick = stat_byte;
                SLOT_HIGH: pick = hi_plain;
                default:   pick = lo_byte;
            endcase
        end else begin
            pick = byte_hi ? hi_byte : lo_byte;
        end
        db_oe  = rd_act;
        db_out = rd_act ? pick : '0;
    end

    assign seq_o = m_q.seq;
endmodule

// File: rtl/adc_bus_if.sv
module adc_bus_if #(
    parameter int MAG_W = 15,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             ce_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             cont_mode,
    input  logic             byte_hi,
    input  logic             ovr_sel,
    input  logic             conv_busy,
    input  logic             res_valid,
    input  logic [MAG_W-1:0] res_mag,
    input  logic             res_neg,
    input  logic             res_ovr,
    output logic [BUS_W-1:0] db_out,
    output logic             db_oe,
    output logic             conv_start
);
    logic             rd_act, wr_act, load, lat_neg, lat_ovr;
    logic [MAG_W-1:0] lat_mag;
    logic [1:0]       seq_w;

    adcbus_decode u_dec (
        .cs(cs), .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n),
        .rd_act(rd_act), .wr_act(wr_act)
    );

    adcbus_start u_start (
        .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .cont_mode(cont_mode),
        .conv_busy(conv_busy), .conv_start(conv_start)
    );

    adcbus_latch #(.MAG_W(MAG_W)) u_lat (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_mag(res_mag),
        .res_neg(res_neg), .res_ovr(res_ovr), .rd_act(rd_act),
        .lat_mag(lat_mag), .lat_neg(lat_neg), .lat_ovr(lat_ovr), .load(load)
    );

    adcbus_mux #(.MAG_W(MAG_W), .BUS_W(BUS_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .cont_mode(cont_mode),
        .byte_hi(byte_hi), .ovr_sel(ovr_sel), .load(load),
        .lat_mag(lat_mag), .lat_neg(lat_neg), .lat_ovr(lat_ovr),
        .db_out(db_out), .db_oe(db_oe), .seq_o(seq_w)
    );
endmodule

// File: rtl/adc_bus_if_chk.sv
module adc_bus_if_chk #(
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs,
    input logic             ce_n,
    input logic             rd_n,
    input logic             wr_n,
    input logic             cont_mode,
    input logic             byte_hi,
    input logic             ovr_sel,
    input logic             conv_busy,
    input logic [BUS_W-1:0] db_out,
    input logic             db_oe,
    input logic             conv_start,
    input logic [1:0]       seq_w
);
    AST_OE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        db_oe |-> (cs && !ce_n && !rd_n)); // R1
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !db_oe |-> (db_out == '0)); // R3
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R2
    AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(cs && !ce_n && !wr_n && !cont_mode && !conv_busy)); // R8
    AST_SEQ_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        seq_w != 2'd3); // R6
    AST_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (db_oe && $past(db_oe) && !cont_mode && $past(!cont_mode)
         && $stable(byte_hi) && $stable(ovr_sel)) |-> $stable(db_out)); // R9
endmodule

bind adc_bus_if adc_bus_if_chk #(.BUS_W(BUS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n),
    .cont_mode(cont_mode), .byte_hi(byte_hi), .ovr_sel(ovr_sel),
    .conv_busy(conv_busy), .db_out(db_out), .db_oe(db_oe),
    .conv_start(conv_start), .seq_w(seq_w)
);

// File: tb/tb_adc_bus_if.sv
module tb_adc_bus_if;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, ce_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic cont_mode = 1'b0, byte_hi = 1'b0, ovr_sel = 1'b0, conv_busy = 1'b0;
    logic res_valid = 1'b0, res_neg = 1'b0, res_ovr = 1'b0;
    logic [14:0] res_mag = '0;
    logic [7:0] db_out;
    logic db_oe, conv_start;

    always #2.5 clk = ~clk;

    adc_bus_if dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n),
        .cont_mode(cont_mode), .byte_hi(byte_hi), .ovr_sel(ovr_sel),
        .conv_busy(conv_busy), .res_valid(res_valid), .res_mag(res_mag),
        .res_neg(res_neg), .res_ovr(res_ovr), .db_out(db_out), .db_oe(db_oe),
        .conv_start(conv_start)
    );

    typedef struct {
        bit         is_start;
        logic       exp_oe;
        logic [7:0] exp_data;
        string      tag;
    } item_t;

    item_t sb[$];
    event  smp;
    int    n_vec = 0, n_bad = 0;
    bit    done = 0;

    // monitor: pops expected items and compares against the ports
    initial forever begin
        item_t it;
        @(smp);
        while (sb.size() > 0) begin
            it = sb.pop_front();
            n_vec++;
            if (it.is_start) begin
                if (conv_start !== it.exp_oe) begin
                    n_bad++;
                    $display("FAIL %s conv_start act=%b exp=%b", it.tag, conv_start, it.exp_oe);
                end
            end else if (db_oe !== it.exp_oe || db_out !== it.exp_data) begin
                n_bad++;
                $display("FAIL %s oe/data act=%b/%h exp=%b/%h", it.tag,
                         db_oe, db_out, it.exp_oe, it.exp_data);
            end
        end
    end

    task automatic push_bus(input logic oe, input logic [7:0] d, input string tag);
        item_t it;
        it.is_start = 0; it.exp_oe = oe; it.exp_data = d; it.tag = tag;
        sb.push_back(it);
        ->smp;
    endtask

    task automatic push_start(input logic v, input string tag);
        item_t it;
        it.is_start = 1; it.exp_oe = v; it.exp_data = '0; it.tag = tag;
        sb.push_back(it);
        ->smp;
    endtask

    task automatic select(input logic c, input logic e);
        cs = c; ce_n = e;
    endtask

    // offer a result, not during a read
    task automatic put_result(input logic [14:0] m, input logic n, input logic o);
        @(negedge clk);
        res_valid = 1; res_mag = m; res_neg = n; res_ovr = o;
        @(negedge clk);
        res_valid = 0;
    endtask

    // one read cycle, expected value sampled mid-read
    task automatic do_read(input logic oe, input logic [7:0] d, input string tag);
        @(negedge clk);
        rd_n = 0;
        #1 push_bus(oe, d, tag);
        @(negedge clk);
        rd_n = 1;
    endtask

    task automatic do_write(input logic exp_pulse, input string tag);
        @(negedge clk);
        wr_n = 0;
        @(negedge clk);
        push_start(exp_pulse, tag);
        @(negedge clk);
        #1 push_start(1'b0, {tag, " second cycle"});
        wr_n = 1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        push_bus(1'b0, 8'h00, "R3 reset bus");
        push_start(1'b0, "R3 reset start");
        rst_n = 1;
        @(negedge clk);

        // demand mode reads, result mag=0x5A3C (hi 0x5A... 15 bits) neg=1 ovr=0
        put_result(15'h5A3C, 1'b1, 1'b0);
        select(1, 0);
        byte_hi = 0; do_read(1, 8'h3C, "R4 low byte");
        byte_hi = 1; ovr_sel = 0; do_read(1, {1'b1, 7'h5A}, "R5 high byte sign");
        ovr_sel = 1; do_read(1, {1'b0, 7'h5A}, "R5 high byte overrange");
        put_result(15'h2381, 1'b0, 1'b1);
        ovr_sel = 0; do_read(1, {1'b0, 7'h23}, "R5 sign positive");
        ovr_sel = 1; do_read(1, {1'b1, 7'h23}, "R5 overrange set");
        byte_hi = 0; do_read(1, 8'h81, "R4 low byte second");

        // selection gating
        select(1, 1); do_read(0, 8'h00, "R1 ce_n high blocks read");
        select(0, 0); do_read(0, 8'h00, "R1 cs low blocks read");
        do_write(1'b0, "R1 write unselected");

        // writes
        select(1, 0);
        do_write(1'b1, "R2 demand write");
        conv_busy = 1; do_write(1'b0, "R8 write while busy"); conv_busy = 0;
        cont_mode = 1; do_write(1'b0, "R8 write continuous");

        // continuous sequence with wrap
        put_result(15'h7F01, 1'b1, 1'b1);
        do_read(1, 8'hC0, "R6 status");
        do_read(1, 8'h7F, "R6 high");
        do_read(1, 8'h01, "R6 low");
        do_read(1, 8'hC0, "R6 wrap to status");
        do_read(1, 8'h7F, "R6 high after wrap");

        // new result restarts sequence
        put_result(15'h0A55, 1'b0, 1'b1);
        do_read(1, 8'h40, "R7 restart status");
        do_read(1, 8'h0A, "R7 then high");

        // result arriving during read is deferred
        cont_mode = 0; byte_hi = 0;
        put_result(15'h1111, 1'b0, 1'b0);
        @(negedge clk);
        rd_n = 0;
        #1 push_bus(1, 8'h11, "R9 before arrival");
        @(negedge clk);
        res_valid = 1; res_mag = 15'h2222;
        @(negedge clk);
        res_valid = 1; res_mag = 15'h3333;
        @(negedge clk);
        res_valid = 0;
        #1 push_bus(1, 8'h11, "R9 held during read");
        @(negedge clk);
        rd_n = 1;
        @(negedge clk);
        do_read(1, 8'h33, "R9 newest applied after read");

        @(negedge clk);
        finish_run();
    end
endmodule